// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns a 16-bit effective address into a full 24-bit memory address by pairing it with an 8-bit bank byte. It holds four registers: a data bank byte, a 16-bit direct-page offset, and two 16-bit index registers (X and Y). Each register is loaded through its own write strobe on the rising clock edge. A 3-bit addressing-mode select and a 16-bit operand then choose how the address is formed. The modes are absolute, direct-page, direct-page indexed, absolute indexed, pre-indexed pointer and post-indexed pointer.

The address path is purely combinational from the registers, the mode select, the operand and the index-width flag. The surrounding sequencer can therefore present a new operand and use the address in the same cycle. Direct-page forms always land in bank zero. A separate output flags when the bank byte has been forced to zero instead of taken from the data bank register.

Top module: `banked_addr_gen`

## Requirements
- R1: Reset (rst_n low) clears the data bank register and the direct offset register to zero. Afterwards, mode 0 with operand 0xBEEF gives 0x00BEEF, and mode 1 with operand 0x1280 gives 0x000080.
- R2: A write strobe loads its register from wr_data on the rising clock edge, and the new value is used from that edge onwards. The data bank register takes wr_data[7:0] and ignores wr_data[15:8]. Several strobes may be high in the same cycle.
- R3: Mode 0 (absolute) outputs {bank, operand}.
- R4: Mode 1 (direct) outputs {0x00, (direct + operand[7:0]) mod 65536}. operand[15:8] has no effect.
- R5: Mode 2 (direct,X) and mode 3 (direct,Y) output {0x00, (direct + operand[7:0] + index) mod 65536}.
- R6: Mode 4 (absolute,X) and mode 5 (absolute,Y) output {bank, (operand + index) mod 65536}. No carry reaches the bank byte.
- R7: Mode 6 (pre-indexed pointer) outputs the bank-zero pointer address {0x00, (direct + operand[7:0] + X) mod 65536}.
- R8: Mode 7 (post-indexed pointer) takes operand as the fetched 16-bit pointer and outputs ({bank, operand} + Y) mod 2^24, with the carry reaching the bank byte.
- R9: When idx_narrow is 1, X and Y act as 8-bit values with a zero high byte. The stored high bytes are kept and reappear when idx_narrow returns to 0. The flag acts in the same cycle it changes.
- R10: addr and bank_zero follow mode and operand changes in the same cycle, with no clock edge in between.
- R11: bank_zero is 1 exactly for modes 1, 2, 3 and 6. When it is 1, addr[23:16] is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for bank and direct registers |
| wr_bank | input | 1 | Load data bank register from wr_data[7:0] |
| wr_direct | input | 1 | Load direct offset register |
| wr_xidx | input | 1 | Load X index register |
| wr_yidx | input | 1 | Load Y index register |
| wr_data | input | 16 | Write data for all registers |
| idx_narrow | input | 1 | Index-width flag: 1 treats X and Y as 8-bit |
| mode | input | 3 | Addressing mode select (0..7) |
| operand | input | 16 | Operand bytes or fetched pointer |
| addr | output | 24 | Formed 24-bit address |
| bank_zero | output | 1 | Bank byte forced to zero |

## Verification
A corrupted register shows on addr in the first cycle that a mode reads it. A bad bank byte shows in modes 0, 4, 5 and 7. A bad direct offset shows in modes 1, 2, 3 and 6. A bad index high byte shows only while idx_narrow is 0. Since the path is combinational, a wrong mode decode or a lost carry shows up at once when the operand is applied. A wrongly loaded register shows one edge after its strobe.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [2:0] {
        AM_ABS      = 3'd0,
        AM_DIR      = 3'd1,
        AM_DIR_X    = 3'd2,
        AM_DIR_Y    = 3'd3,
        AM_ABS_X    = 3'd4,
        AM_ABS_Y    = 3'd5,
        AM_PTR_PRE  = 3'd6,
        AM_PTR_POST = 3'd7
    } amode_e;

    localparam int IDX_X = 0;
    localparam int IDX_Y = 1;
    localparam int N_IDX = 2;
endpackage

// File: rtl/bag_regs.sv
module bag_regs #(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_bank,
    input  logic                              wr_direct,
    input  logic [bag_pkg::N_IDX-1:0]         wr_idx,
    input  logic [AW-1:0]                     wr_data,
    output logic [BW-1:0]                     bank_q,
    output logic [AW-1:0]                     direct_q,
    output logic [bag_pkg::N_IDX-1:0][AW-1:0] idx_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q   <= '0;
            direct_q <= '0;
        end else begin
            if (wr_bank)   bank_q   <= wr_data[BW-1:0];
            if (wr_direct) direct_q <= wr_data;
        end
    end

    // Index registers carry no reset: software loads them before use.
    for (genvar i = 0; i < bag_pkg::N_IDX; i++) begin : g_idx
        always_ff @(posedge clk) begin
            if (wr_idx[i]) idx_q[i] <= wr_data;
        end
    end

    assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bank |=> bank_q == $past(wr_data[BW-1:0]));
    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_bank |=> $stable(bank_q));
    assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_direct |=> direct_q == $past(wr_data));
endmodule

// File: rtl/bag_idx_view.sv
module bag_idx_view #(
    parameter int AW = 16
) (
    input  logic                              narrow,
    input  logic [bag_pkg::N_IDX-1:0][AW-1:0] idx_q,
    output logic [bag_pkg::N_IDX-1:0][AW-1:0] idx_eff
);
    localparam int NW = AW / 2;

    for (genvar i = 0; i < bag_pkg::N_IDX; i++) begin : g_view
        always_comb begin
            idx_eff[i] = idx_q[i];
            if (narrow) idx_eff[i][AW-1:NW] = '0;
        end
    end
endmodule

// File: rtl/bag_addr_calc.sv
module bag_addr_calc #(
    parameter int AW = 16,
    parameter int BW = 8,
    parameter int DW = 8
) (
    input  bag_pkg::amode_e   mode,
    input  logic [AW-1:0]     operand,
    input  logic [BW-1:0]     bank,
    input  logic [AW-1:0]     direct,
    input  logic [AW-1:0]     x_eff,
    input  logic [AW-1:0]     y_eff,
    output logic [BW+AW-1:0]  addr,
    output logic              bank_zero
);
    import bag_pkg::*;
    localparam int FW = BW + AW;

    logic [AW-1:0] dp_base;
    logic [AW-1:0] dp_x;
    logic [AW-1:0] dp_y;
    logic [AW-1:0] abs_x;
    logic [AW-1:0] abs_y;
    logic [FW-1:0] post_sum;

    always_comb begin
        dp_base  = direct + {{(AW-DW){1'b0}}, operand[DW-1:0]};
        dp_x     = dp_base + x_eff;
        dp_y     = dp_base + y_eff;
        abs_x    = operand + x_eff;
        abs_y    = operand + y_eff;
        post_sum = {bank, operand} + {{BW{1'b0}}, y_eff};
    end

    always_comb begin
        unique case (mode)
            AM_ABS:      begin addr = {bank, operand};     bank_zero = 1'b0; end
            AM_DIR:      begin addr = {{BW{1'b0}}, dp_base}; bank_zero = 1'b1; end
            AM_DIR_X:    begin addr = {{BW{1'b0}}, dp_x};  bank_zero = 1'b1; end
            AM_DIR_Y:    begin addr = {{BW{1'b0}}, dp_y};  bank_zero = 1'b1; end
            AM_ABS_X:    begin addr = {bank, abs_x};       bank_zero = 1'b0; end
            AM_ABS_Y:    begin addr = {bank, abs_y};       bank_zero = 1'b0; end
            AM_PTR_PRE:  begin addr = {{BW{1'b0}}, dp_x};  bank_zero = 1'b1; end
            AM_PTR_POST: begin addr = post_sum;            bank_zero = 1'b0; end
            default:     begin addr = '0;                  bank_zero = 1'b0; end
        endcase
    end
endmodule

// File: rtl/banked_addr_gen.sv
module banked_addr_gen #(
    parameter int AW = 16,
    parameter int BW = 8,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_bank,
    input  logic             wr_direct,
    input  logic             wr_xidx,
    input  logic             wr_yidx,
    input  logic [AW-1:0]    wr_data,
    input  logic             idx_narrow,
    input  logic [2:0]       mode,
    input  logic [AW-1:0]    operand,
    output logic [BW+AW-1:0] addr,
    output logic             bank_zero
);
    import bag_pkg::*;
    localparam int FW = BW + AW;

    logic [BW-1:0]             bank_q;
    logic [AW-1:0]             direct_q;
    logic [N_IDX-1:0][AW-1:0]  idx_q;
    logic [N_IDX-1:0][AW-1:0]  idx_eff;
    logic [N_IDX-1:0]          wr_idx;
    amode_e                    mode_e;

    assign wr_idx = {wr_yidx, wr_xidx};
    assign mode_e = amode_e'(mode);

    bag_regs #(.AW(AW), .BW(BW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_bank(wr_bank), .wr_direct(wr_direct),
        .wr_idx(wr_idx), .wr_data(wr_data),
        .bank_q(bank_q), .direct_q(direct_q), .idx_q(idx_q)
    );

    bag_idx_view #(.AW(AW)) u_view (
        .narrow(idx_narrow), .idx_q(idx_q), .idx_eff(idx_eff)
    );

    bag_addr_calc #(.AW(AW), .BW(BW), .DW(DW)) u_calc (
        .mode(mode_e), .operand(operand), .bank(bank_q), .direct(direct_q),
        .x_eff(idx_eff[IDX_X]), .y_eff(idx_eff[IDX_Y]),
        .addr(addr), .bank_zero(bank_zero)
    );

    logic [AW-1:0] abs_delta;
    logic [FW-1:0] post_delta;
    assign abs_delta  = addr[AW-1:0] - operand;
    assign post_delta = addr - {bank_q, operand};

    assert_zero_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bank_zero |-> addr[FW-1:AW] == '0);
    assert_abs_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 || mode == 3'd5) |-> addr[FW-1:AW] == bank_q);
    assert_narrow_abs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_narrow && mode == 3'd4) |-> abs_delta[AW-1:AW/2] == '0);
    assert_narrow_post_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_narrow && mode == 3'd7) |-> post_delta[FW-1:AW/2] == '0);
    assert_abs_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd0 |-> (addr[AW-1:0] == operand && !bank_zero));
endmodule

// File: tb/tb_banked_addr_gen.sv
module tb_banked_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_bank = 1'b0, wr_direct = 1'b0, wr_xidx = 1'b0, wr_yidx = 1'b0;
    logic [15:0] wr_data = '0;
    logic        idx_narrow = 1'b0;
    logic [2:0]  mode = '0;
    logic [15:0] operand = '0;
    logic [23:0] addr;
    logic        bank_zero;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    banked_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_bank(wr_bank), .wr_direct(wr_direct),
        .wr_xidx(wr_xidx), .wr_yidx(wr_yidx), .wr_data(wr_data),
        .idx_narrow(idx_narrow), .mode(mode), .operand(operand),
        .addr(addr), .bank_zero(bank_zero)
    );

    task automatic chk(input string tag, input logic [23:0] exp_a, input logic exp_bz);
        checks++;
        if (addr !== exp_a || bank_zero !== exp_bz) begin
            errors++;
            $display("FAIL %s: addr=%06h bz=%0b expected addr=%06h bz=%0b",
                     tag, addr, bank_zero, exp_a, exp_bz);
        end
    endtask

    task automatic apply(input logic [2:0] m, input logic [15:0] op);
        mode = m; operand = op; #2;
    endtask

    task automatic wr(input logic b, input logic d, input logic x, input logic y,
                      input logic [15:0] v);
        @(negedge clk);
        wr_bank = b; wr_direct = d; wr_xidx = x; wr_yidx = y; wr_data = v;
        @(negedge clk);
        wr_bank = 0; wr_direct = 0; wr_xidx = 0; wr_yidx = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        apply(3'd0, 16'hBEEF); chk("R1 abs after reset", 24'h00BEEF, 1'b0);
        apply(3'd1, 16'h1280); chk("R1 dir after reset", 24'h000080, 1'b1);
    endtask

    task automatic t_load;
        wr(1, 0, 0, 0, 16'hAA7E);
        wr(0, 1, 1, 0, 16'hFFF0);   // D and X both loaded, X fixed below
        wr(0, 0, 1, 0, 16'h1234);
        wr(0, 0, 0, 1, 16'h00FF);
        @(negedge clk);
        apply(3'd0, 16'h4000); chk("R2 R3 abs with bank", 24'h7E4000, 1'b0);
        // R2: timing of a write relative to the edge
        @(negedge clk);
        wr_bank = 1; wr_data = 16'h0033;
        #2 chk("R2 before edge", 24'h7E4000, 1'b0);
        @(posedge clk); #2;
        wr_bank = 0;
        chk("R2 after edge", 24'h334000, 1'b0);
        wr(1, 0, 0, 0, 16'h007E);
    endtask

    task automatic t_direct;
        @(negedge clk);
        apply(3'd1, 16'h3320); chk("R4 direct wrap, high op ignored", 24'h000010, 1'b1);
        apply(3'd2, 16'h0005); chk("R5 direct X", 24'h001229, 1'b1);
        apply(3'd3, 16'h0005); chk("R5 direct Y", 24'h0000F4, 1'b1);
    endtask

    task automatic t_abs_idx;
        @(negedge clk);
        apply(3'd4, 16'hF000); chk("R6 abs X no bank carry", 24'h7E0234, 1'b0);
        apply(3'd5, 16'h1000); chk("R6 abs Y", 24'h7E10FF, 1'b0);
    endtask

    task automatic t_ptr;
        @(negedge clk);
        apply(3'd6, 16'h0010); chk("R7 pre-index pointer", 24'h001234, 1'b1);
        apply(3'd7, 16'hFF80); chk("R8 post-index bank carry", 24'h7F007F, 1'b0);
        apply(3'd5, 16'hFF80); chk("R6 abs Y same sum wraps", 24'h7E007F, 1'b0);
    endtask

    task automatic t_narrow;
        wr(0, 0, 0, 1, 16'hAB01);
        @(negedge clk);
        idx_narrow = 1;
        apply(3'd4, 16'hF000); chk("R9 narrow X", 24'h7EF034, 1'b0);
        apply(3'd7, 16'h0010); chk("R9 narrow Y post", 24'h7E0011, 1'b0);
        idx_narrow = 0; #2;
        chk("R9 wide Y restored", 24'h7EAB11, 1'b0);
        idx_narrow = 1; #2;
        apply(3'd2, 16'h0005); chk("R9 narrow X direct", 24'h000029, 1'b1);
        idx_narrow = 0;
    endtask

    task automatic t_comb;
        @(negedge clk);
        apply(3'd0, 16'h0001); chk("R10 first operand", 24'h7E0001, 1'b0);
        apply(3'd0, 16'h0002); chk("R10 second operand same cycle", 24'h7E0002, 1'b0);
        apply(3'd6, 16'h0002); chk("R10 R11 mode change same cycle", 24'h001226, 1'b1);
    endtask

    task automatic t_rereset;
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        apply(3'd4, 16'h0100); chk("R1 bank cleared again", 24'h001334, 1'b0);
        apply(3'd1, 16'h0044); chk("R1 direct cleared again", 24'h000044, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_load();
        t_direct();
        t_abs_idx();
        t_ptr();
        t_narrow();
        t_comb();
        t_rereset();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule